// File: doc/BRIEF.md
# Serial Bus Timing Generator

This block produces the timing that a telecom PCM/ADPCM serial port needs to move its data. It runs on the master clock and supports two bus modes, and it picks the mode by itself from the frame-pulse input. In timeslot mode a short low-going frame pulse marks each 125 µs frame. The block then counts master-clock cycles through the frame. From that count it drives a bit clock at half the master rate, a delayed frame marker and two 8-bit-wide channel enables. In strobe mode an external bit clock and two enable strobes are supplied instead. The block synchronises them to the master clock and turns their edges into strobes.

In both modes the shift registers that sit next to this block receive the same signals: a sample strobe, a launch strobe and a two-bit channel-window indication. Every output that must release the line carries a separate output-enable, so the pad logic can tristate it.

Top module: `ssb_timing_gen`

## Requirements
- R1: While reset is held, and after it is released with the frame pulse idle high and the external inputs low, the block is in strobe mode (busModeTs=0). sampleStb, launchStb, bitClkOutOe, chan2EnOe and framePulseDlyOe are all 0.
- R2: A frame pulse that is low for exactly one master cycle is valid. Call E0 the clock edge at which the low level is sampled. At edge E0+2 the block enters timeslot mode and its cycle count restarts at 0. During that cycle framePulseDlyN is 0.
- R3: A frame pulse that stays low for two or more master cycles is not valid, and the block stays in strobe mode.
- R4: In timeslot mode, bitClkOut is 1 in even frame cycles and 0 in odd frame cycles, which gives half the master rate. bitClkOutOe is 1.
- R5: In timeslot mode, chan1En is 1 in frame cycles 0 to 15 (bits 0 to 7). chan2En is 1 in frame cycles 16 to 31 (bits 8 to 15). Both are 0 in all other cycles. slotAct[0] and slotAct[1] carry the same values.
- R6: In timeslot mode, launchStb is 1 in the first master cycle of each bit and sampleStb is 1 in the second. The two strobes are never 1 together.
- R7: In timeslot mode without further pulses, the count wraps after 512 cycles. framePulseDlyN goes low again in frame cycle 0 of the next frame.
- R8: In strobe mode, bitClkIn passes through a two-stage synchroniser. The cycle after the second sampling edge of a rising bitClkIn has launchStb=1 for one cycle. A falling bitClkIn does the same with sampleStb.
- R9: In strobe mode, bitClkOutOe, framePulseDlyOe and chan2EnOe are 0, and chan1EnOe equals linearMode. slotAct[0] and chan1En follow strobe1In, and slotAct[1] follows strobe2In, each after the same two-stage synchronisation.
- R10: When valid pulses arrive every 512 cycles, timeslot mode is kept. If no valid pulse arrives for more than 1024 cycles (two frames), the block returns to strobe mode.
- R11: A valid pulse that arrives in the middle of a frame restarts the count at 0 at once, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (4.096 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| framePulseN | input | 1 | Frame pulse, active low |
| bitClkIn | input | 1 | External bit clock (strobe mode) |
| strobe1In | input | 1 | External channel-1 enable strobe |
| strobe2In | input | 1 | External channel-2 enable strobe |
| linearMode | input | 1 | Linear PCM selected; keeps chan1 enable driven in strobe mode |
| busModeTs | output | 1 | 1 = timeslot mode, 0 = strobe mode |
| bitClkOut | output | 1 | Half-rate bit clock |
| bitClkOutOe | output | 1 | Output enable for bitClkOut |
| framePulseDlyN | output | 1 | Delayed frame marker, active low |
| framePulseDlyOe | output | 1 | Output enable for framePulseDlyN |
| chan1En | output | 1 | Channel 1 enable, active high |
| chan1EnOe | output | 1 | Output enable for chan1En |
| chan2En | output | 1 | Channel 2 enable, active high |
| chan2EnOe | output | 1 | Output enable for chan2En |
| slotAct | output | 2 | Channel windows for the shift registers (bit0 = ch1, bit1 = ch2) |
| sampleStb | output | 1 | Input-data sample strobe |
| launchStb | output | 1 | Output-data launch strobe |

## Verification
In one cycle a valid frame pulse can arrive while the cycle counter would otherwise just increment. To provoke this, the bench sends a pulse 100 cycles into a running frame. It then checks that the delayed marker, the bit clock and the channel-1 enable all show frame cycle 0 two edges after the pulse, not the cycle the count would have reached. The loss timer can also expire close to a pulse arriving. The bench judges this case by keeping a train of pulses 512 cycles apart, which must hold timeslot mode. It then drops the pulses and checks that the mode is still held at 1000 idle cycles and has fallen back to strobe mode by 1100.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic       tsMode;   // timeslot mode active
    logic       restart;  // valid frame pulse seen, restart frame count
    logic       extRise;  // synchronised rising edge of external bit clock
    logic       extFall;  // synchronised falling edge of external bit clock
    logic [1:0] extSlot;  // synchronised external enable strobes
  } ssbCtl_t;
endpackage

// File: rtl/ssb_ctrl.sv
module ssb_ctrl
  import ssb_pkg::*;
#(
  parameter int FRAME_CYCLES = 512,
  parameter int LOSS_FRAMES  = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    framePulseN,
  input  logic    bitClkIn,
  input  logic    strobe1In,
  input  logic    strobe2In,
  output ssbCtl_t ctl
);
  localparam int LOSS_LIMIT = FRAME_CYCLES * LOSS_FRAMES;
  localparam int LOSS_W     = $clog2(LOSS_LIMIT + 1);
  localparam int NUM_EXT    = 3;

  // Frame-pulse history: fpHist[0] newest
  logic [2:0] fpHist;
  logic       pulseValid;
  logic       tsMode;
  logic [LOSS_W-1:0] lossCnt;

  always_ff @(posedge clk) begin
    if (!rstN) fpHist <= 3'b111;
    else       fpHist <= {fpHist[1:0], framePulseN};
  end

  // Exactly one low sample between two high samples
  assign pulseValid = fpHist[0] & ~fpHist[1] & fpHist[2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsMode  <= 1'b0;
      lossCnt <= LOSS_W'(LOSS_LIMIT);
    end else if (pulseValid) begin
      tsMode  <= 1'b1;
      lossCnt <= '0;
    end else if (lossCnt == LOSS_W'(LOSS_LIMIT)) begin
      tsMode  <= 1'b0;
    end else begin
      lossCnt <= lossCnt + 1'b1;
    end
  end

  // Synchronisers for the external strobe-mode inputs
  logic [NUM_EXT-1:0] extRaw;
  logic [NUM_EXT-1:0] extSync;
  logic               bitClkPrev;

  assign extRaw = {strobe2In, strobe1In, bitClkIn};

  for (genvar gi = 0; gi < NUM_EXT; gi++) begin : g_sync
    logic [SYNC_STAGES-1:0] stage;
    always_ff @(posedge clk) begin
      if (!rstN) stage <= '0;
      else       stage <= {stage[SYNC_STAGES-2:0], extRaw[gi]};
    end
    assign extSync[gi] = stage[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) bitClkPrev <= 1'b0;
    else       bitClkPrev <= extSync[0];
  end

  always_comb begin
    ctl.tsMode  = tsMode;
    ctl.restart = pulseValid;
    ctl.extRise = extSync[0] & ~bitClkPrev;
    ctl.extFall = ~extSync[0] & bitClkPrev;
    ctl.extSlot = extSync[2:1];
  end
endmodule

// File: rtl/ssb_datapath.sv
module ssb_datapath
  import ssb_pkg::*;
#(
  parameter int FRAME_CYCLES = 512,
  parameter int CHAN_BITS    = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    linearMode,
  input  ssbCtl_t ctl,
  output logic    bitClkOut,
  output logic    bitClkOutOe,
  output logic    framePulseDlyN,
  output logic    framePulseDlyOe,
  output logic    chan1En,
  output logic    chan1EnOe,
  output logic    chan2En,
  output logic    chan2EnOe,
  output logic [1:0] slotAct,
  output logic    sampleStb,
  output logic    launchStb
);
  localparam int CNT_W = $clog2(FRAME_CYCLES);
  localparam int BIT_W = CNT_W - 1;
  localparam logic [BIT_W-1:0] SLOT1_END = BIT_W'(CHAN_BITS);
  localparam logic [BIT_W-1:0] SLOT2_END = BIT_W'(2 * CHAN_BITS);

  logic [CNT_W-1:0] frameCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             halfSel;
  logic [1:0]       tsSlot;

  always_ff @(posedge clk) begin
    if (!rstN)            frameCnt <= '0;
    else if (ctl.restart) frameCnt <= '0;
    else if (ctl.tsMode)  frameCnt <= frameCnt + 1'b1;
    else                  frameCnt <= '0;
  end

  assign bitIdx  = frameCnt[CNT_W-1:1];
  assign halfSel = frameCnt[0];

  always_comb begin
    tsSlot[0] = bitIdx < SLOT1_END;
    tsSlot[1] = (bitIdx >= SLOT1_END) && (bitIdx < SLOT2_END);
  end

  always_comb begin
    slotAct         = ctl.tsMode ? tsSlot : ctl.extSlot;
    bitClkOut       = ctl.tsMode & ~halfSel;
    bitClkOutOe     = ctl.tsMode;
    framePulseDlyN  = ~(ctl.tsMode && (frameCnt == '0));
    framePulseDlyOe = ctl.tsMode;
    chan1En         = slotAct[0];
    chan1EnOe       = ctl.tsMode | linearMode;
    chan2En         = slotAct[1];
    chan2EnOe       = ctl.tsMode;
    sampleStb       = ctl.tsMode ? halfSel  : ctl.extFall;
    launchStb       = ctl.tsMode ? ~halfSel : ctl.extRise;
  end
endmodule

// File: rtl/ssb_timing_gen.sv
module ssb_timing_gen
  import ssb_pkg::*;
#(
  parameter int FRAME_CYCLES = 512,
  parameter int CHAN_BITS    = 8,
  parameter int LOSS_FRAMES  = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       framePulseN,
  input  logic       bitClkIn,
  input  logic       strobe1In,
  input  logic       strobe2In,
  input  logic       linearMode,
  output logic       busModeTs,
  output logic       bitClkOut,
  output logic       bitClkOutOe,
  output logic       framePulseDlyN,
  output logic       framePulseDlyOe,
  output logic       chan1En,
  output logic       chan1EnOe,
  output logic       chan2En,
  output logic       chan2EnOe,
  output logic [1:0] slotAct,
  output logic       sampleStb,
  output logic       launchStb
);
  ssbCtl_t ctl;

  ssb_ctrl #(
    .FRAME_CYCLES(FRAME_CYCLES),
    .LOSS_FRAMES (LOSS_FRAMES),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .framePulseN(framePulseN),
    .bitClkIn   (bitClkIn),
    .strobe1In  (strobe1In),
    .strobe2In  (strobe2In),
    .ctl        (ctl)
  );

  ssb_datapath #(
    .FRAME_CYCLES(FRAME_CYCLES),
    .CHAN_BITS   (CHAN_BITS)
  ) i_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .linearMode     (linearMode),
    .ctl            (ctl),
    .bitClkOut      (bitClkOut),
    .bitClkOutOe    (bitClkOutOe),
    .framePulseDlyN (framePulseDlyN),
    .framePulseDlyOe(framePulseDlyOe),
    .chan1En        (chan1En),
    .chan1EnOe      (chan1EnOe),
    .chan2En        (chan2En),
    .chan2EnOe      (chan2EnOe),
    .slotAct        (slotAct),
    .sampleStb      (sampleStb),
    .launchStb      (launchStb)
  );

  assign busModeTs = ctl.tsMode;
endmodule

// File: rtl/ssb_timing_chk.sv
module ssb_timing_chk (
  input logic       clk,
  input logic       rstN,
  input logic       framePulseN,
  input logic       bitClkIn,
  input logic       strobe1In,
  input logic       strobe2In,
  input logic       linearMode,
  input logic       busModeTs,
  input logic       bitClkOut,
  input logic       bitClkOutOe,
  input logic       framePulseDlyN,
  input logic       framePulseDlyOe,
  input logic       chan1En,
  input logic       chan1EnOe,
  input logic       chan2En,
  input logic       chan2EnOe,
  input logic [1:0] slotAct,
  input logic       sampleStb,
  input logic       launchStb
);
  // R6: sample and launch never coincide
  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStb && launchStb));

  // R4: a high bit-clock phase is followed by a low one unless the frame restarts
  a_r4_bitclk_alternates: assert property (@(posedge clk) disable iff (!rstN)
    (busModeTs && bitClkOut) |=> (!bitClkOut || !busModeTs || !framePulseDlyN));

  // R5: channel windows never overlap in timeslot mode
  a_r5_slots_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    busModeTs |-> $countones({chan1En, chan2En}) <= 1);

  // R2: frame marker lines up with the first bit of channel 1
  a_r2_marker_aligned: assert property (@(posedge clk) disable iff (!rstN)
    !framePulseDlyN |-> (busModeTs && chan1En && bitClkOut && launchStb));

  // R9: strobe-mode output enables
  a_r9_strobe_oe: assert property (@(posedge clk) disable iff (!rstN)
    !busModeTs |-> (!bitClkOutOe && !framePulseDlyOe && !chan2EnOe && (chan1EnOe == linearMode)));

  // R8: a strobe-mode launch lasts a single cycle
  a_r8_launch_single: assert property (@(posedge clk) disable iff (!rstN)
    (!busModeTs && launchStb) |=> (!launchStb || busModeTs));
endmodule

bind ssb_timing_gen ssb_timing_chk i_chk (.*);

// File: tb/test_ssb_timing_gen.sv
module test_ssb_timing_gen;
  localparam time CLK_PERIOD = 244ns;
  localparam int  NVEC = 12;
  // {frame cycle offset, bitClkOut, chan1En, chan2En, sampleStb, launchStb, framePulseDlyN}
  localparam logic [21:0] VEC [0:NVEC-1] = '{
    {16'd0,   6'b110010},
    {16'd1,   6'b010101},
    {16'd2,   6'b110011},
    {16'd15,  6'b010101},
    {16'd16,  6'b101011},
    {16'd17,  6'b001101},
    {16'd31,  6'b001101},
    {16'd32,  6'b100011},
    {16'd33,  6'b000101},
    {16'd255, 6'b000101},
    {16'd510, 6'b100011},
    {16'd511, 6'b000101}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic framePulseN = 1'b1;
  logic bitClkIn = 1'b0;
  logic strobe1In = 1'b0;
  logic strobe2In = 1'b0;
  logic linearMode = 1'b0;
  logic busModeTs, bitClkOut, bitClkOutOe, framePulseDlyN, framePulseDlyOe;
  logic chan1En, chan1EnOe, chan2En, chan2EnOe, sampleStb, launchStb;
  logic [1:0] slotAct;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssb_timing_gen i_ssb_timing_gen (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Low for exactly one sampling edge; returns at the negedge after it
  task automatic sendPulse();
    @(negedge clk) framePulseN = 1'b0;
    @(negedge clk) framePulseN = 1'b1;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    int cur;
    step(4);
    // R1: state during and after reset
    chk("R1 mode in reset", busModeTs, 0);
    rstN = 1'b1;
    step(3);
    chk("R1 mode", busModeTs, 0);
    chk("R1 strobes", {sampleStb, launchStb}, 0);
    chk("R1 oe", {bitClkOutOe, chan2EnOe, framePulseDlyOe}, 0);

    // R3: long low pulse is rejected
    @(negedge clk) framePulseN = 1'b0;
    step(3);
    framePulseN = 1'b1;
    step(6);
    chk("R3 long pulse ignored", busModeTs, 0);
    chk("R3 marker oe", framePulseDlyOe, 0);

    // R8: external bit clock edges
    bitClkIn = 1'b1;
    step(1);
    chk("R8 rise not yet", launchStb, 0);
    step(1);
    chk("R8 launch pulse", {launchStb, sampleStb}, 2'b10);
    step(1);
    chk("R8 launch single", launchStb, 0);
    bitClkIn = 1'b0;
    step(2);
    chk("R8 sample pulse", {sampleStb, launchStb}, 2'b10);
    step(1);
    chk("R8 sample single", sampleStb, 0);

    // R9: strobe-mode enables
    chk("R9 chan1 oe linear off", chan1EnOe, 0);
    linearMode = 1'b1;
    #1;
    chk("R9 chan1 oe linear on", chan1EnOe, 1);
    strobe1In = 1'b1;
    step(2);
    chk("R9 slot follows strobe1", {slotAct, chan1En}, 3'b011);
    strobe1In = 1'b0;
    strobe2In = 1'b1;
    step(2);
    chk("R9 slot follows strobe2", {slotAct, chan2En, chan2EnOe}, 4'b1010);
    strobe2In = 1'b0;
    linearMode = 1'b0;
    step(2);

    // R2 R4 R5 R6: walk the timeslot vector table
    sendPulse();
    step(2);
    chk("R2 timeslot mode", {busModeTs, bitClkOutOe, chan1EnOe, chan2EnOe}, 4'hF);
    cur = 0;
    for (int i = 0; i < NVEC; i++) begin
      step(int'(VEC[i][21:6]) - cur);
      cur = int'(VEC[i][21:6]);
      chk($sformatf("R4/R5/R6/R2 offset %0d", cur),
          {bitClkOut, chan1En, chan2En, sampleStb, launchStb, framePulseDlyN}, VEC[i][5:0]);
      chk($sformatf("R5 slotAct offset %0d", cur), slotAct, {VEC[i][3], VEC[i][4]});
    end

    // R7: free-running wrap
    step(1);
    chk("R7 wrap marker", {framePulseDlyN, chan1En, bitClkOut}, 3'b011);
    step(1);
    chk("R7 marker one cycle", framePulseDlyN, 1);

    // R11: resync in mid-frame
    step(98);
    sendPulse();
    step(2);
    chk("R11 resync marker", {framePulseDlyN, chan1En, bitClkOut, launchStb}, 4'b0111);
    step(17);
    chk("R11 resync chan2 start", {chan1En, chan2En}, 2'b01);

    // R10: periodic pulses keep mode, loss falls back
    step(493);
    for (int f = 0; f < 3; f++) begin
      sendPulse();
      step(510);
    end
    chk("R10 kept by pulses", busModeTs, 1);
    step(1000 - 510);
    chk("R10 held before timeout", busModeTs, 1);
    step(100);
    chk("R10 loss fallback", {busModeTs, bitClkOutOe, framePulseDlyOe}, 0);

    done = 1'b1;
    report();
  end
endmodule